// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block is the alarm side of a real-time clock. The time keeper that sits beside it presents the running date and time as BCD values, together with a one-cycle strobe in the cycle in which a freshly advanced second is valid. On each strobe the block compares that time against six programmed alarm fields. A field takes part only when its own enable bit is set. If any single enabled field matches, the block latches an alarm pending flag. That flag drives a level interrupt.

Software reaches the block through a small register port. The port holds a control word, the six alarm fields and a pending register. Each stored field keeps only the bits that its BCD range needs. The pending flag stays set until software writes a one to its bit position. The pending register also reflects a tick flag, which the neighbouring tick generator supplies.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, the control word, all six alarm fields, the pending register (with tick_pend_i low) and alarm_irq_o all read 0.
- R2: Writes mask each field before storing it: the control word (address 1) keeps 7 bits (0x7F), seconds (addr 2) and minutes (addr 3) keep 0x7F, hours (addr 4) and day of month (addr 5) keep 0x3F, month (addr 6) keeps 0x1F, and year (addr 7, three BCD digits) keeps 0xFFF.
- R3: Control bits 0 to 5 enable comparison of seconds, minutes, hours, day of month, month and year respectively. A field whose bit is clear never causes an alarm, even when it matches.
- R4: Control bit 6 is the global alarm enable. While it is clear, no match raises the alarm.
- R5: The per-field results are ORed. A match on one enabled field raises the alarm even when other enabled fields differ. The month is compared as the raw BCD value presented.
- R6: Comparison takes place only in cycles where sec_tick_i is high. A match in such a cycle sets the pending flag at the next clock edge, and no other cycle can set it.
- R7: alarm_irq_o is high exactly while the alarm pending flag is set. The flag holds until software clears it, and a further match while it is pending has no visible effect.
- R8: Writing to address 0 with data bit 1 set clears the flag and lowers alarm_irq_o on the next edge. A write with bit 1 clear changes nothing. A set and a clear in the same cycle leave the flag set.
- R9: Reading address 0 returns the alarm flag in bit 1 and tick_pend_i in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle strobe: the current time has just advanced |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| cur_day_i | input | 8 | Current day of month, BCD |
| cur_mon_i | input | 8 | Current month, BCD |
| cur_year_i | input | 12 | Current year, three BCD digits |
| tick_pend_i | input | 1 | Tick flag, shown in bit 0 of the pending register |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 pending, 1 control, 2..7 alarm fields) |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data, combinational from reg_addr_i |
| alarm_irq_o | output | 1 | Level alarm interrupt |

## Verification
On every cycle, the assertions check the following: the flag can rise only after a strobe cycle in which the global enable was set, a match always comes from some enabled field, the flag holds while no clear is written, and a clear with no competing set drops it. The bench scenarios cover the rest: field masking, the bit order of the per-field enables, the OR across fields, a same-cycle set and clear, and the pending register layout. These depend on particular programmed values that a cycle-local property cannot pick out.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 12;
  localparam int NUM_FIELDS = 6;
  localparam int CTRL_W     = NUM_FIELDS + 1;
  localparam int GLOBAL_BIT = NUM_FIELDS;
  localparam int FIELD_BASE = 2;
  localparam int PEND_ALARM_BIT = 1;
  localparam int PEND_TICK_BIT  = 0;

  // stored width per field: sec, min, hour, day, mon, year
  localparam int FIELD_W [NUM_FIELDS] = '{7, 7, 6, 6, 5, 12};

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PEND = 3'd0,
    ADDR_CTRL = 3'd1
  } reg_addr_e;

  typedef logic [DATA_W-1:0] field_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  field_t            wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output field_t            field_o [NUM_FIELDS]
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
  end
  assign ctrl_o = ctrl_q;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FIELD_BASE + g);
    localparam field_t            MASK    = DATA_W'((1 << FIELD_W[g]) - 1);
    field_t fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fld_q <= '0;
      else if (we_i && addr_i == MY_ADDR) fld_q <= wdata_i & MASK;
    end
    assign field_o[g] = fld_q;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  field_t            field_i [NUM_FIELDS],
  input  field_t            cur_i   [NUM_FIELDS],
  output logic              match_o
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_hit
    assign hit[g] = ctrl_i[g] && (field_i[g] == cur_i[g]);
  end

  assign match_o = tick_i && ctrl_i[GLOBAL_BIT] && (|hit);

  AST_MATCH_FROM_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (ctrl_i[NUM_FIELDS-1:0] != '0)); // R3
endmodule

// File: rtl/rtc_alarm_pend.sv
module rtc_alarm_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // set has priority so a new event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end
  assign pend_o = pend_q;

  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_q); // R8
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic [7:0]        cur_sec_i,
  input  logic [7:0]        cur_min_i,
  input  logic [7:0]        cur_hour_i,
  input  logic [7:0]        cur_day_i,
  input  logic [7:0]        cur_mon_i,
  input  logic [11:0]       cur_year_i,
  input  logic              tick_pend_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              alarm_irq_o
);
  logic [CTRL_W-1:0] ctrl;
  field_t            field [NUM_FIELDS];
  field_t            cur   [NUM_FIELDS];
  logic              match, clr, pend;

  assign cur[0] = DATA_W'(cur_sec_i);
  assign cur[1] = DATA_W'(cur_min_i);
  assign cur[2] = DATA_W'(cur_hour_i);
  assign cur[3] = DATA_W'(cur_day_i);
  assign cur[4] = DATA_W'(cur_mon_i);
  assign cur[5] = cur_year_i;

  rtc_alarm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .field_o (field)
  );

  rtc_alarm_cmp u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sec_tick_i),
    .ctrl_i  (ctrl),
    .field_i (field),
    .cur_i   (cur),
    .match_o (match)
  );

  assign clr = reg_we_i && (reg_addr_i == ADDR_PEND) && reg_wdata_i[PEND_ALARM_BIT];

  rtc_alarm_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (match),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign alarm_irq_o = pend;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_PEND) begin
      reg_rdata_o[PEND_ALARM_BIT] = pend;
      reg_rdata_o[PEND_TICK_BIT]  = tick_pend_i;
    end else if (reg_addr_i == ADDR_CTRL) begin
      reg_rdata_o = DATA_W'(ctrl);
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (reg_addr_i == ADDR_W'(FIELD_BASE + i)) reg_rdata_o = field[i];
    end
  end

  AST_SET_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_irq_o) |-> $past(sec_tick_i)); // R6
  AST_SET_NEEDS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_irq_o) |-> $past(ctrl[GLOBAL_BIT])); // R4
endmodule

// File: tb/rtc_alarm_match_tb.sv
`timescale 1ns/1ps
module rtc_alarm_match_tb;
  logic        clk = 0, rst_ni = 0, sec_tick = 0, tick_pend = 0, we = 0;
  logic [7:0]  c_sec = 0, c_min = 0, c_hour = 0, c_day = 8'h01, c_mon = 8'h01;
  logic [11:0] c_year = 0, wdata = 0, rdata, rv;
  logic [2:0]  addr = 0;
  logic        irq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_match u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sec_tick_i(sec_tick),
    .cur_sec_i(c_sec), .cur_min_i(c_min), .cur_hour_i(c_hour),
    .cur_day_i(c_day), .cur_mon_i(c_mon), .cur_year_i(c_year),
    .tick_pend_i(tick_pend), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .alarm_irq_o(irq)
  );

  localparam int NV = 11;
  localparam logic [6:0]  TV_CTRL [NV] = '{7'h41,7'h42,7'h44,7'h48,7'h50,7'h60,7'h01,7'h7E,7'h43,7'h40,7'h7F};
  localparam logic [7:0]  TV_SEC  [NV] = '{8'h30,8'h00,8'h00,8'h00,8'h00,8'h00,8'h30,8'h30,8'h00,8'h30,8'h00};
  localparam logic [7:0]  TV_MIN  [NV] = '{8'h00,8'h15,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h15,8'h15,8'h00};
  localparam logic [7:0]  TV_HOUR [NV] = '{8'h00,8'h00,8'h12,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h12,8'h00};
  localparam logic [7:0]  TV_DAY  [NV] = '{8'h01,8'h01,8'h01,8'h25,8'h01,8'h01,8'h01,8'h01,8'h01,8'h25,8'h01};
  localparam logic [7:0]  TV_MON  [NV] = '{8'h01,8'h01,8'h01,8'h01,8'h07,8'h01,8'h01,8'h01,8'h01,8'h07,8'h01};
  localparam logic [11:0] TV_YEAR [NV] = '{12'h000,12'h000,12'h000,12'h000,12'h000,12'h123,12'h000,12'h000,12'h000,12'h123,12'h000};
  localparam logic        TV_EXP  [NV] = '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0};
  localparam string       TV_REQ  [NV] = '{"R3","R3","R3","R3","R5","R3","R4","R3","R5","R3","R5"};

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [11:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [11:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic set_cur(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                         logic [7:0] d, logic [7:0] mo, logic [11:0] y);
    c_sec = s; c_min = mi; c_hour = h; c_day = d; c_mon = mo; c_year = y;
  endtask

  task automatic program_alarm();
    wr(3'd2, 12'h030); wr(3'd3, 12'h015); wr(3'd4, 12'h012);
    wr(3'd5, 12'h025); wr(3'd6, 12'h007); wr(3'd7, 12'h123);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv); chk("R1", rv, 12'h000);
    end
    chk("R1", {11'b0, irq}, 12'h000);

    // R2 masking
    begin
      logic [11:0] mexp [8] = '{12'h000,12'h07F,12'h07F,12'h07F,12'h03F,12'h03F,12'h01F,12'hFFF};
      for (int a = 1; a < 8; a++) begin
        wr(3'(a), 12'hFFF); rd(3'(a), rv); chk("R2", rv, mexp[a]);
      end
    end
    wr(3'd1, 12'h000);
    program_alarm();

    // vector table: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, 12'(TV_CTRL[i]));
      set_cur(TV_SEC[i], TV_MIN[i], TV_HOUR[i], TV_DAY[i], TV_MON[i], TV_YEAR[i]);
      pulse_tick();
      chk(TV_REQ[i], {11'b0, irq}, {11'b0, TV_EXP[i]});
      wr(3'd0, 12'h002);
      chk("R8", {11'b0, irq}, 12'h000);
    end

    // R6 match without strobe does nothing
    wr(3'd1, 12'h041);
    set_cur(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
    repeat (5) @(negedge clk);
    chk("R6", {11'b0, irq}, 12'h000);
    rd(3'd0, rv); chk("R6", rv, 12'h000);
    pulse_tick();
    chk("R6", {11'b0, irq}, 12'h001);

    // R7 hold and repeat match
    pulse_tick();
    rd(3'd0, rv); chk("R7", rv, 12'h002);
    repeat (10) @(negedge clk);
    chk("R7", {11'b0, irq}, 12'h001);

    // R8 write without bit 1, then clear
    wr(3'd0, 12'h001);
    chk("R8", {11'b0, irq}, 12'h001);
    wr(3'd0, 12'h002);
    chk("R8", {11'b0, irq}, 12'h000);

    // R8 set and clear in same cycle: set wins
    @(negedge clk); sec_tick = 1; we = 1; addr = 3'd0; wdata = 12'h002;
    @(negedge clk); sec_tick = 0; we = 0; wdata = 0;
    chk("R8", {11'b0, irq}, 12'h001);

    // R9 pending layout with tick flag
    tick_pend = 1;
    rd(3'd0, rv); chk("R9", rv, 12'h003);
    wr(3'd0, 12'h002);
    rd(3'd0, rv); chk("R9", rv, 12'h001);
    tick_pend = 0;
    rd(3'd0, rv); chk("R9", rv, 12'h000);

    finish_run();
  end
endmodule